// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is an SPI slave that looks, from the bus, like a small byte-wide serial EEPROM. A host selects it with an active-low chip select. The host shifts 8-bit commands and data in on the serial input, MSB first, and reads results back on the serial output. The block keeps a write-enable latch and a small status register. It also holds a byte array whose size is set by `ADDR_BITS`. Writes go first into a page buffer of `2**PAGE_BITS` bytes. Programming only begins when chip select is released.

All logic runs on a fast system clock. The three SPI inputs pass through synchronizers and are edge-detected, so SCK must be several system clocks slower. Both SPI clock polarities with sample-on-rising are accepted (modes 0 and 3). The serial output comes as a data bit plus an enable, so the pad can tri-state it. After a page write or status write, a timed internal cycle of `WRITE_CYCLES` system clocks keeps the device busy. During that cycle only the status read is obeyed.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status register reads 0x00: not busy, write-enable latch clear, protection bits clear. `so_oe` is low.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect at the end of its opcode byte. The latch is visible as status bit 1.
- R3: Opcode 0x05 returns the status register MSB first on `so`, repeated for every further byte. The layout is: bit 0 busy, bit 1 write-enable latch, bits 2, 3 and 7 stored, bits 4 to 6 zero. `so_oe` is low while an opcode is shifted in and whenever chip select is high.
- R4: Write opcode 0x02 is obeyed only while the write-enable latch is set. Otherwise the frame is ignored and no internal cycle starts.
- R5: After a write (0x02) or read (0x03) opcode come two address bytes, high byte first. Only the low `ADDR_BITS` bits select a location; the upper bits are don't-care.
- R6: Each data byte of a write goes to the current page offset. Only the offset advances, modulo `2**PAGE_BITS`, so bytes past the page end wrap to its start and overwrite earlier bytes of the same frame.
- R7: Programming starts when chip select rises after at least one complete data byte. Page locations that received no byte keep their old content.
- R8: An internal cycle holds status bit 0 at 1 for exactly `WRITE_CYCLES` system clocks.
- R9: While busy, every opcode except 0x05 is ignored for the rest of its frame. This includes 0x04, 0x06 and reads, which leave `so_oe` low.
- R10: The write-enable latch clears automatically when an internal cycle ends.
- R11: Opcode 0x01 with the latch set takes one data byte. On chip-select rise it copies only bits 7, 3 and 2 into the status register and starts an internal cycle. Without the latch the frame is ignored.
- R12: A chip-select rise when the bit count is not a multiple of 8 aborts the frame. No internal cycle starts and no write or latch change happens.
- R13: Read opcode 0x03 returns the byte at the given address and then the bytes that follow. The address advances across page boundaries and wraps from the last array location to location 0.
- R14: SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) both work. Input is sampled on the SCK rising edge and output changes on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so`; low means high impedance |

## Verification
The assertions assume the SPI inputs are slow compared with the system clock. Each SCK phase lasts longer than the synchronizer delay plus one clock, and chip select changes only while SCK is quiet, well away from any SCK edge. Under those assumptions a byte completion and a chip-select rise never fall in the same system clock. The bench holds every SCK half period for six system clocks and leaves several clocks of margin on each side of a chip-select change. It also waits for a status read showing ready before any write whose effect it checks.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_WDATA,
      ST_RDATA,
      ST_STAT_RD,
      ST_STAT_WR,
      ST_SKIP
   } ee_state_e;

   localparam logic [7:0] OPC_STAT_WR  = 8'h01;
   localparam logic [7:0] OPC_WRITE    = 8'h02;
   localparam logic [7:0] OPC_READ     = 8'h03;
   localparam logic [7:0] OPC_WE_CLR   = 8'h04;
   localparam logic [7:0] OPC_STAT_RD  = 8'h05;
   localparam logic [7:0] OPC_WE_SET   = 8'h06;

   // status bits that a status write may change
   localparam logic [7:0] STAT_WR_MASK = 8'h8C;

endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   input  logic [7:0] tx_byte,
   input  logic       tx_oe,
   output logic       cs_act,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       frame_end,
   output logic       frame_aligned,
   output logic       so,
   output logic       so_oe
);

   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] cs_q, sck_q, si_q;
   logic         cs_s, sck_s, si_s;
   logic         cs_d, sck_d;
   logic         sck_rise, sck_fall, cs_rise;
   logic [2:0]   bit_cnt;
   logic [6:0]   rx_sh;
   logic [7:0]   tx_sh;
   logic         oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= '1;
         sck_q <= '0;
         si_q  <= '0;
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_q  <= {cs_q[TOP-1:0], cs_n};
         sck_q <= {sck_q[TOP-1:0], sck};
         si_q  <= {si_q[TOP-1:0], si};
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign cs_s     = cs_q[TOP];
   assign sck_s    = sck_q[TOP];
   assign si_s     = si_q[TOP];
   assign cs_act   = ~cs_s;
   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign cs_rise  = cs_s & ~cs_d;

   // receive side: sample on rising SCK
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt       <= '0;
         rx_sh         <= '0;
         rx_byte       <= '0;
         byte_done     <= 1'b0;
         frame_end     <= 1'b0;
         frame_aligned <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         frame_end <= 1'b0;
         if (cs_rise) begin
            frame_end     <= 1'b1;
            frame_aligned <= (bit_cnt == 3'd0);
         end
         if (!cs_act) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            rx_sh   <= {rx_sh[5:0], si_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh, si_s};
            end
         end
      end
   end

   // transmit side: load at a byte boundary, shift on falling SCK
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         oe_q  <= 1'b0;
      end else if (!cs_act) begin
         tx_sh <= '0;
         oe_q  <= 1'b0;
      end else if (sck_fall) begin
         if (bit_cnt == 3'd0) begin
            tx_sh <= tx_byte;
            oe_q  <= tx_oe;
         end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
         end
      end
   end

   assign so    = tx_sh[7] & oe_q;
   assign so_oe = oe_q;

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
   import spi_ee_pkg::*;
#(
   parameter int ADDR_BITS = 11,
   parameter int PAGE_BITS = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           byte_done,
   input  logic [7:0]                     rx_byte,
   input  logic                           frame_end,
   input  logic                           frame_aligned,
   input  logic                           busy,
   input  logic                           cycle_done,
   input  logic [7:0]                     rd_data,
   input  logic [PAGE_BITS-1:0]           commit_idx,
   output logic [7:0]                     tx_byte,
   output logic                           tx_oe,
   output logic [ADDR_BITS-1:0]           rd_addr,
   output logic                           start,
   output logic                           page_mode,
   output logic [ADDR_BITS-PAGE_BITS-1:0] page_addr,
   output logic [7:0]                     commit_data,
   output logic                           commit_valid,
   output logic                           wel
);

   localparam int PAGE_BYTES = 1 << PAGE_BITS;
   localparam int PG_W       = ADDR_BITS - PAGE_BITS;

   ee_state_e               state;
   logic                    is_read;
   logic                    have_data;
   logic [PAGE_BITS-1:0]    offset;
   logic [PG_W-1:0]         page_q;
   logic [ADDR_BITS-1:0]    rd_ptr;
   logic [7:0]              stat_keep;
   logic [7:0]              stat_pend;
   logic [PAGE_BYTES-1:0]   mask;
   logic [7:0]              pbuf [PAGE_BYTES];
   logic [ADDR_BITS-1:0]    full_addr;
   logic [7:0]              status;
   logic                    wr_slot;

   // address assembly: keep only the high address bits that are used
   if (ADDR_BITS > 8) begin : g_wide
      logic [ADDR_BITS-9:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hi_q <= '0;
         else if (byte_done && state == ST_ADDR_HI)
            hi_q <= rx_byte[ADDR_BITS-9:0];
      end
      assign full_addr = {hi_q, rx_byte};
   end else begin : g_narrow
      assign full_addr = rx_byte[ADDR_BITS-1:0];
   end

   assign status = {stat_keep[7], 3'b000, stat_keep[3:2], wel, busy};
   assign start  = frame_end && frame_aligned && have_data &&
                   (state == ST_WDATA || state == ST_STAT_WR);
   assign page_mode = (state == ST_WDATA);
   assign page_addr = page_q;
   assign rd_addr   = rd_ptr;
   assign wr_slot   = byte_done && (state == ST_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OPC;
         is_read   <= 1'b0;
         have_data <= 1'b0;
         offset    <= '0;
         page_q    <= '0;
         rd_ptr    <= '0;
         stat_keep <= '0;
         stat_pend <= '0;
         mask      <= '0;
         wel       <= 1'b0;
      end else begin
         if (frame_end) begin
            state <= ST_OPC;
            if (start && state == ST_STAT_WR)
               stat_keep <= stat_pend & STAT_WR_MASK;
         end else if (byte_done) begin
            unique case (state)
               ST_OPC: begin
                  if (busy) begin
                     state <= (rx_byte == OPC_STAT_RD) ? ST_STAT_RD : ST_SKIP;
                  end else begin
                     state <= ST_SKIP;
                     case (rx_byte)
                        OPC_WE_SET: wel <= 1'b1;
                        OPC_WE_CLR: wel <= 1'b0;
                        OPC_STAT_RD: state <= ST_STAT_RD;
                        OPC_STAT_WR: if (wel) begin
                           state     <= ST_STAT_WR;
                           have_data <= 1'b0;
                        end
                        OPC_WRITE: if (wel) begin
                           state   <= ST_ADDR_HI;
                           is_read <= 1'b0;
                        end
                        OPC_READ: begin
                           state   <= ST_ADDR_HI;
                           is_read <= 1'b1;
                        end
                        default: ;
                     endcase
                  end
               end
               ST_ADDR_HI: state <= ST_ADDR_LO;
               ST_ADDR_LO: begin
                  if (is_read) begin
                     rd_ptr <= full_addr;
                     state  <= ST_RDATA;
                  end else begin
                     page_q    <= full_addr[ADDR_BITS-1:PAGE_BITS];
                     offset    <= full_addr[PAGE_BITS-1:0];
                     mask      <= '0;
                     have_data <= 1'b0;
                     state     <= ST_WDATA;
                  end
               end
               ST_WDATA: begin
                  mask[offset] <= 1'b1;
                  offset       <= offset + 1'b1;
                  have_data    <= 1'b1;
               end
               ST_RDATA: rd_ptr <= rd_ptr + 1'b1;
               ST_STAT_WR: begin
                  stat_pend <= rx_byte;
                  have_data <= 1'b1;
               end
               default: ;
            endcase
         end
         if (cycle_done)
            wel <= 1'b0;
      end
   end

   // page buffer: one register per slot
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pbuf[g] <= '0;
         else if (wr_slot && offset == PAGE_BITS'(g))
            pbuf[g] <= rx_byte;
      end
   end

   assign commit_data  = pbuf[commit_idx];
   assign commit_valid = mask[commit_idx];

   always_comb begin
      tx_byte = '0;
      tx_oe   = 1'b0;
      case (state)
         ST_STAT_RD: begin
            tx_byte = status;
            tx_oe   = 1'b1;
         end
         ST_RDATA: begin
            tx_byte = rd_data;
            tx_oe   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/spi_ee_commit.sv
module spi_ee_commit #(
   parameter int ADDR_BITS    = 11,
   parameter int PAGE_BITS    = 5,
   parameter int WRITE_CYCLES = 400
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           page_mode,
   input  logic [ADDR_BITS-PAGE_BITS-1:0] page_addr,
   input  logic [7:0]                     cdata,
   input  logic                           cvalid,
   output logic                           busy,
   output logic                           cycle_done,
   output logic [PAGE_BITS-1:0]           idx,
   output logic                           we,
   output logic [ADDR_BITS-1:0]           waddr,
   output logic [7:0]                     wdata
);

   localparam int CW = $clog2(WRITE_CYCLES + 1);
   localparam logic [CW-1:0] LAST   = CW'(WRITE_CYCLES - 1);
   localparam logic [CW-1:0] NSLOTS = CW'(1 << PAGE_BITS);

   logic [CW-1:0] cnt;
   logic          pm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cycle_done <= 1'b0;
         cnt        <= '0;
         pm_q       <= 1'b0;
      end else begin
         cycle_done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            pm_q <= page_mode;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
               busy       <= 1'b0;
               cycle_done <= 1'b1;
            end
         end
      end
   end

   // one buffered byte is written per clock during the first page-size cycles
   assign idx   = cnt[PAGE_BITS-1:0];
   assign we    = busy && pm_q && (cnt < NSLOTS) && cvalid;
   assign waddr = {page_addr, idx};
   assign wdata = cdata;

endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
   parameter int ADDR_BITS = 11
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [ADDR_BITS-1:0] waddr,
   input  logic [7:0]           wdata,
   input  logic [ADDR_BITS-1:0] raddr,
   output logic [7:0]           rdata
);

   localparam int DEPTH = 1 << ADDR_BITS;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
   parameter int ADDR_BITS    = 11,
   parameter int PAGE_BITS    = 5,
   parameter int WRITE_CYCLES = 400,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic so,
   output logic so_oe
);

   localparam int PG_W = ADDR_BITS - PAGE_BITS;

   if (ADDR_BITS < 4 || ADDR_BITS > 16) begin : g_bad_addr
      $error("ADDR_BITS must lie in 4..16");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_BITS) begin : g_bad_page
      $error("PAGE_BITS must lie in 1..ADDR_BITS-1");
   end
   if (WRITE_CYCLES < (1 << PAGE_BITS)) begin : g_bad_cyc
      $error("WRITE_CYCLES must cover one page");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                 cs_act, byte_done, frame_end, frame_aligned;
   logic [7:0]           rx_byte, tx_byte;
   logic                 tx_oe;
   logic                 busy, cycle_done, start, page_mode, wel;
   logic [PG_W-1:0]      page_addr;
   logic [7:0]           commit_data, rd_data, wdata;
   logic                 commit_valid, mem_we;
   logic [PAGE_BITS-1:0] commit_idx;
   logic [ADDR_BITS-1:0] waddr, rd_addr;

   spi_ee_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .tx_byte(tx_byte), .tx_oe(tx_oe), .cs_act(cs_act),
      .byte_done(byte_done), .rx_byte(rx_byte), .frame_end(frame_end),
      .frame_aligned(frame_aligned), .so(so), .so_oe(so_oe)
   );

   spi_ee_ctrl #(.ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
      .frame_end(frame_end), .frame_aligned(frame_aligned), .busy(busy),
      .cycle_done(cycle_done), .rd_data(rd_data), .commit_idx(commit_idx),
      .tx_byte(tx_byte), .tx_oe(tx_oe), .rd_addr(rd_addr), .start(start),
      .page_mode(page_mode), .page_addr(page_addr),
      .commit_data(commit_data), .commit_valid(commit_valid), .wel(wel)
   );

   spi_ee_commit #(
      .ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS), .WRITE_CYCLES(WRITE_CYCLES)
   ) u_commit (
      .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
      .page_addr(page_addr), .cdata(commit_data), .cvalid(commit_valid),
      .busy(busy), .cycle_done(cycle_done), .idx(commit_idx), .we(mem_we),
      .waddr(waddr), .wdata(wdata)
   );

   spi_ee_mem #(.ADDR_BITS(ADDR_BITS)) u_mem (
      .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
      .raddr(rd_addr), .rdata(rd_data)
   );

endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
   parameter int WRITE_CYCLES = 400
) (
   input logic clk,
   input logic rst_n,
   input logic cs_act,
   input logic so_oe,
   input logic busy,
   input logic cycle_done,
   input logic wel,
   input logic mem_we,
   input logic frame_end,
   input logic frame_aligned
);

   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + 1;
      else
         run_cnt <= '0;
   end

   assert_so_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !so_oe);

   assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_cnt == WRITE_CYCLES);

   assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |-> !busy && $past(busy));

   assert_start_on_aligned_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(frame_end && frame_aligned));

   assert_write_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !wel);

   assert_no_latch_set_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> !busy);

endmodule

bind spi_eeprom_slave spi_ee_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .so_oe(so_oe), .busy(busy),
   .cycle_done(cycle_done), .wel(wel), .mem_we(mem_we),
   .frame_end(frame_end), .frame_aligned(frame_aligned)
);

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;

   localparam int AB    = 8;
   localparam int PB    = 4;
   localparam int WCYC  = 1000;
   localparam int DEPTH = 1 << AB;
   localparam int PSZ   = 1 << PB;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic si = 1'b0;
   logic so, so_oe;
   logic mode3 = 1'b0;
   logic finished = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [DEPTH];

   always #4 clk = ~clk;

   spi_eeprom_slave #(
      .ADDR_BITS(AB), .PAGE_BITS(PB), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)
   ) u_spi_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so(so), .so_oe(so_oe)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cs_begin();
      sck = mode3;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_end();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic xbits(input logic [7:0] d, input int n,
                        output logic [7:0] r, output logic oe0);
      r = '0;
      oe0 = 1'b0;
      for (int i = 7; i > 7 - n; i--) begin
         if (mode3) sck = 1'b0;
         si = d[i];
         repeat (HALF) @(negedge clk);
         r[i] = so;
         if (i == 7) oe0 = so_oe;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] d, output logic [7:0] r, output logic oe0);
      xbits(d, 8, r, oe0);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      logic oe;
      cs_begin();
      xfer(op, r, oe);
      cs_end();
   endtask

   task automatic rdsr(output logic [7:0] st);
      logic [7:0] r;
      logic oe;
      cs_begin();
      xfer(8'h05, r, oe);
      check("R3 opcode phase so_oe", int'(oe), 0);
      xfer(8'h00, st, oe);
      check("R3 status phase so_oe", int'(oe), 1);
      cs_end();
   endtask

   task automatic wait_ready(input string tag, output logic [7:0] st);
      int n = 0;
      rdsr(st);
      while (st[0] && n < 40) begin
         rdsr(st);
         n++;
      end
      check(tag, int'(st[0]), 0);
   endtask

   // write n bytes first, first+step, ... starting at {hi,lo}; update model per R6
   task automatic page_write(input logic [7:0] hi, input logic [7:0] lo, input int n,
                             input logic [7:0] first, input logic [7:0] step);
      logic [7:0] r;
      logic oe;
      logic [7:0] v = first;
      int base = int'(lo) & (DEPTH - 1) & ~(PSZ - 1);
      cs_begin();
      xfer(8'h02, r, oe);
      xfer(hi, r, oe);
      xfer(lo, r, oe);
      for (int i = 0; i < n; i++) begin
         xfer(v, r, oe);
         model[base + ((int'(lo) + i) % PSZ)] = v;
         v = v + step;
      end
      cs_end();
   endtask

   task automatic read_chk(input string tag, input logic [7:0] hi, input logic [7:0] lo,
                           input int n);
      logic [7:0] r;
      logic oe;
      cs_begin();
      xfer(8'h03, r, oe);
      xfer(hi, r, oe);
      xfer(lo, r, oe);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, r, oe);
         check(tag, int'(r), int'(model[(int'(lo) + i) % DEPTH]));
      end
      cs_end();
   endtask

   initial begin
      logic [7:0] st, r;
      logic oe;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      check("R1 so_oe after reset", int'(so_oe), 0);
      rdsr(st);
      check("R1 status after reset", int'(st), 8'h00);

      // R2 latch set / clear, in mode 3 (R14)
      mode3 = 1'b1;
      cmd1(8'h06);
      rdsr(st);
      check("R2 R14 latch set", int'(st), 8'h02);
      cmd1(8'h04);
      rdsr(st);
      check("R2 R14 latch clear", int'(st), 8'h00);

      // sweep: fill every page, junk high address byte (R5), alternate modes (R14)
      for (int pg = 0; pg < DEPTH / PSZ; pg++) begin
         logic [7:0] base = 8'(pg * PSZ);
         mode3 = pg[0];
         cmd1(8'h06);
         page_write(8'(pg * 17 + 1), base, PSZ, 8'(int'(base) * 37 + 11), 8'd37);
         rdsr(st);
         check("R8 busy with latch after page write", int'(st), 8'h03);
         wait_ready("R8 busy clears", st);
         check("R10 latch cleared after cycle", int'(st), 8'h00);
      end
      mode3 = 1'b0;
      // R13 full read with wrap at array end, start near the end
      read_chk("R13 sequential read", 8'h00, 8'(DEPTH - 8), DEPTH + 4);

      // R6 wrap inside page: 20 bytes from offset 13 of page at 0x20
      cmd1(8'h06);
      page_write(8'h00, 8'h2D, 20, 8'hC0, 8'd1);
      wait_ready("R6 ready", st);
      read_chk("R6 page wrap", 8'h00, 8'h20, PSZ);

      // R7 partial page: only 3 bytes change
      mode3 = 1'b1;
      cmd1(8'h06);
      page_write(8'h00, 8'h54, 3, 8'h71, 8'd2);
      wait_ready("R7 ready", st);
      read_chk("R7 R14 partial page", 8'h00, 8'h50, PSZ);
      mode3 = 1'b0;

      // R4 write without latch is ignored
      begin
         logic [7:0] keep = model[8'h60];
         cs_begin();
         xfer(8'h02, r, oe);
         xfer(8'h00, r, oe);
         xfer(8'h60, r, oe);
         xfer(~keep, r, oe);
         cs_end();
         rdsr(st);
         check("R4 no cycle without latch", int'(st), 8'h00);
         read_chk("R4 location unchanged", 8'h00, 8'h60, 1);
      end

      // R9 commands ignored while busy
      cmd1(8'h06);
      page_write(8'h00, 8'h70, 1, 8'h3C, 8'd0);
      cmd1(8'h04);
      rdsr(st);
      check("R9 latch-clear ignored while busy", int'(st), 8'h03);
      cs_begin();
      xfer(8'h03, r, oe);
      xfer(8'h00, r, oe);
      xfer(8'h70, r, oe);
      xfer(8'h00, r, oe);
      check("R9 read refused while busy, so_oe", int'(oe), 0);
      cs_end();
      wait_ready("R9 ready", st);
      check("R10 latch cleared", int'(st), 8'h00);
      read_chk("R9 byte committed", 8'h00, 8'h70, 1);

      // R11 status write
      cs_begin();
      xfer(8'h01, r, oe);
      xfer(8'hFF, r, oe);
      cs_end();
      rdsr(st);
      check("R11 status write without latch ignored", int'(st), 8'h00);
      cmd1(8'h06);
      cs_begin();
      xfer(8'h01, r, oe);
      xfer(8'hFF, r, oe);
      cs_end();
      rdsr(st);
      check("R11 only bits 7,3,2 stored, busy", int'(st), 8'h8F);
      wait_ready("R11 ready", st);
      check("R11 R10 status after cycle", int'(st), 8'h8C);
      cmd1(8'h06);
      cs_begin();
      xfer(8'h01, r, oe);
      xfer(8'h70, r, oe);
      cs_end();
      wait_ready("R11 ready 2", st);
      check("R11 status cleared", int'(st), 8'h00);

      // R12 aborted frames
      cmd1(8'h06);
      begin
         logic [7:0] keep = model[8'h80];
         cs_begin();
         xfer(8'h02, r, oe);
         xfer(8'h00, r, oe);
         xfer(8'h80, r, oe);
         xfer(~keep, r, oe);
         xbits(8'hA5, 5, r, oe);
         cs_end();
         rdsr(st);
         check("R12 aborted write: no cycle, latch kept", int'(st), 8'h02);
         read_chk("R12 location unchanged", 8'h00, 8'h80, 1);
      end
      cmd1(8'h04);
      cs_begin();
      xbits(8'h06, 5, r, oe);
      cs_end();
      rdsr(st);
      check("R12 partial opcode ignored", int'(st), 8'h00);

      // R5 high address byte ignored on read
      read_chk("R5 upper address bits ignored", 8'hFF, 8'h10, 2);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule